// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Update

This block turns a fast input clock into a stream of one-cycle enable pulses whose average rate is the input rate divided by a fixed-point divisor. The divisor field has an integer part and a fraction of sixteenths, so rates between integer ratios come out on average. The block also carries a parent-select value that downstream muxing logic reads. A phase accumulator gains sixteen per enabled input cycle. It emits a pulse whenever it reaches the scaled divisor, then removes the divisor and keeps the remainder.

New divisor and select values are written into staging registers first. They reach the divider only after software writes a 1 to the trigger. The trigger then reads back busy until the update is applied. The update waits for the clock gate to be open and takes effect on an accumulator wrap, so the pulse stream never shows a short or torn period. While the select value names no real parent, the enable output stays low.

Top module: `fracClkDivider`

## Requirements
- R1: After reset, `trigBusy` is 0, `activeSel` holds the reset select value 7, and `clkEnOut` is 0.
- R2: The divisor field has 12 bits. Bits [11:4] hold the integer part minus one and bits [3:0] hold the fraction in sixteenths, so the divisor is field/16 + 1. Over the N gated cycles that follow an update, `clkEnOut` is high on exactly floor(16·N / (field + 16)) cycles.
- R3: With field 0 (divisor 1.0), a valid select and the gate open, `clkEnOut` is high on every cycle.
- R4: A trigger write makes `trigBusy` read 1 on the next cycle. While the gate stays open, the update lands on the first accumulator wrap, at most ceil((field+16)/16) cycles later, measured with the field that was active. `trigBusy` then reads 0 and `activeSel` shows the staged select.
- R5: Staging writes without a trigger change neither the pulse rate nor `activeSel`.
- R6: While `gateEn` is 0, `clkEnOut` stays 0 and a pending update is held with `trigBusy` at 1. After the gate reopens, the update completes.
- R7: A select value of 5 or above names no parent. It forces `clkEnOut` low, and `activeSel` still reports the value.
- R8: While `trigBusy` is 1, staging writes and further trigger writes are ignored. The update applies the values that were staged when the trigger was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rstN | input | 1 | Active-low synchronous reset |
| gateEn | input | 1 | Clock gate open; the accumulator advances only when high |
| divWrEn | input | 1 | Stage `divWrData` into the divisor staging register |
| divWrData | input | 12 | Divisor field: integer-minus-one above four fraction bits |
| selWrEn | input | 1 | Stage `selWrData` into the select staging register |
| selWrData | input | 3 | Parent select value to stage |
| trigWr | input | 1 | Write of 1 to the trigger bit |
| trigBusy | output | 1 | Trigger read-back: 1 while an update is pending |
| clkEnOut | output | 1 | Divided clock-enable pulse |
| activeSel | output | 3 | Parent select value in effect |

## Verification
`trigBusy` rises one cycle after the trigger write. The update takes effect on the edge where the accumulator wraps, and `trigBusy` and `activeSel` change on that same edge. Each `clkEnOut` value belongs to the edge before the falling clock edge where it is sampled. The bench drives and samples only on falling edges. It counts the busy cycles after a trigger and checks that count against the wrap bound computed from the divisor that was active. It leaves out the pulse seen on the update edge, which still belongs to the old setting, and counts pulses over the N edges that follow. A sweep of divisor fields, from 0 to the largest value, is compared with the floor formula.

// File: rtl/fdivPkg.sv
package fdivPkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic advance;   // gate open: accumulator steps this cycle
    logic commit;    // staged divisor becomes active, accumulator restarts
    logic outAllow;  // active select names a real parent
  } fdivStrobeT;

endpackage

// File: rtl/fdivDatapath.sv
module fdivDatapath
  import fdivPkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fdivStrobeT              strobes,
  input  logic [INT_W+FRAC_W-1:0] activeDiv,
  output logic                    hit,
  output logic                    pulse
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic [ACC_W-1:0] scaledDiv;
  logic [ACC_W-1:0] sum;

  // Scaled divisor: stored field plus one unit above the fraction bits.
  assign scaledDiv = {1'b0, activeDiv} + ONE;
  assign sum       = acc + ONE;
  assign hit       = (sum >= scaledDiv);

  always_comb begin
    accNext = acc;
    if (strobes.commit) begin
      accNext = '0;
    end else if (strobes.advance) begin
      accNext = hit ? (sum - scaledDiv) : sum;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else begin
      acc   <= accNext;
      pulse <= strobes.advance & hit & strobes.outAllow;
    end
  end

endmodule

// File: rtl/fdivCtrl.sv
module fdivCtrl
  import fdivPkg::*;
#(
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SEL_W       = 3,
  parameter int NUM_PARENTS = 5,
  parameter int RESET_SEL   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    gateEn,
  input  logic                    divWrEn,
  input  logic [INT_W+FRAC_W-1:0] divWrData,
  input  logic                    selWrEn,
  input  logic [SEL_W-1:0]        selWrData,
  input  logic                    trigWr,
  input  logic                    hit,
  output fdivStrobeT              strobes,
  output logic [INT_W+FRAC_W-1:0] activeDiv,
  output logic [SEL_W-1:0]        activeSel,
  output logic                    trigBusy
);

  localparam int DIV_W = INT_W + FRAC_W;
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(RESET_SEL);

  logic             pending;
  logic [DIV_W-1:0] stageDiv;
  logic [SEL_W-1:0] stageSel;
  logic             selValid;
  logic             commitNow;

  // Selector validity: a full code space needs no comparison.
  generate
    if (NUM_PARENTS >= (1 << SEL_W)) begin : gFullSel
      assign selValid = 1'b1;
    end else begin : gPartSel
      localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PARENTS - 1);
      assign selValid = (activeSel <= LAST_SEL);
    end
  endgenerate

  assign commitNow = pending & gateEn & hit;

  assign strobes.advance  = gateEn;
  assign strobes.commit   = commitNow;
  assign strobes.outAllow = selValid;
  assign trigBusy         = pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= 1'b0;
      stageDiv  <= '0;
      stageSel  <= SEL_RST;
      activeDiv <= '0;
      activeSel <= SEL_RST;
    end else begin
      if (!pending) begin
        if (divWrEn) stageDiv <= divWrData;
        if (selWrEn) stageSel <= selWrData;
      end
      if (commitNow) begin
        activeDiv <= stageDiv;
        activeSel <= stageSel;
        pending   <= 1'b0;
      end else if (trigWr) begin
        pending   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fracClkDivider.sv
module fracClkDivider
  import fdivPkg::*;
#(
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SEL_W       = 3,
  parameter int NUM_PARENTS = 5,
  parameter int RESET_SEL   = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    gateEn,
  input  logic                    divWrEn,
  input  logic [INT_W+FRAC_W-1:0] divWrData,
  input  logic                    selWrEn,
  input  logic [SEL_W-1:0]        selWrData,
  input  logic                    trigWr,
  output logic                    trigBusy,
  output logic                    clkEnOut,
  output logic [SEL_W-1:0]        activeSel
);

  localparam int DIV_W = INT_W + FRAC_W;

  fdivStrobeT       strobes;
  logic [DIV_W-1:0] activeDiv;
  logic             hit;

  fdivCtrl #(
    .INT_W      (INT_W),
    .FRAC_W     (FRAC_W),
    .SEL_W      (SEL_W),
    .NUM_PARENTS(NUM_PARENTS),
    .RESET_SEL  (RESET_SEL)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .gateEn   (gateEn),
    .divWrEn  (divWrEn),
    .divWrData(divWrData),
    .selWrEn  (selWrEn),
    .selWrData(selWrData),
    .trigWr   (trigWr),
    .hit      (hit),
    .strobes  (strobes),
    .activeDiv(activeDiv),
    .activeSel(activeSel),
    .trigBusy (trigBusy)
  );

  fdivDatapath #(
    .INT_W (INT_W),
    .FRAC_W(FRAC_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .activeDiv(activeDiv),
    .hit      (hit),
    .pulse    (clkEnOut)
  );

endmodule

// File: rtl/fracClkDivider_checker.sv
module fracClkDividerChecker #(
  parameter int SEL_W       = 3,
  parameter int NUM_PARENTS = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             gateEn,
  input logic             trigWr,
  input logic             trigBusy,
  input logic             clkEnOut,
  input logic [SEL_W-1:0] activeSel
);

  localparam logic [SEL_W:0] PARENTS = (SEL_W+1)'(NUM_PARENTS);

  // R4: a trigger write while idle shows busy on the next cycle
  assert_busy_after_trigger_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trigWr && !trigBusy) |=> trigBusy);

  // R4: busy only rises because of a trigger write
  assert_busy_from_trigger_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigBusy) |-> $past(trigWr));

  // R6: an update completes only on a cycle with the gate open
  assert_commit_needs_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigBusy) |-> $past(gateEn));

  // R6: no enable pulse results from a gated cycle
  assert_no_pulse_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    clkEnOut |-> $past(gateEn));

  // R5: the select output changes only when an update completes
  assert_sel_moves_on_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSel) |-> $fell(trigBusy));

  // R7: a pulse needs a select value that names a parent
  assert_undefined_sel_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkEnOut |-> ({1'b0, $past(activeSel)} < PARENTS));

endmodule

bind fracClkDivider fracClkDividerChecker #(
  .SEL_W      (SEL_W),
  .NUM_PARENTS(NUM_PARENTS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .gateEn   (gateEn),
  .trigWr   (trigWr),
  .trigBusy (trigBusy),
  .clkEnOut (clkEnOut),
  .activeSel(activeSel)
);

// File: tb/sim_fracClkDivider.sv
`timescale 1ns/1ps
module sim_fracClkDivider;

  localparam int NPULSE = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        gateEn = 1'b0;
  logic        divWrEn = 1'b0;
  logic [11:0] divWrData = '0;
  logic        selWrEn = 1'b0;
  logic [2:0]  selWrData = '0;
  logic        trigWr = 1'b0;
  logic        trigBusy;
  logic        clkEnOut;
  logic [2:0]  activeSel;

  int checks = 0;
  int fails = 0;
  int curScaled = 16;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fracClkDivider u0 (
    .clk      (clk),
    .rstN     (rstN),
    .gateEn   (gateEn),
    .divWrEn  (divWrEn),
    .divWrData(divWrData),
    .selWrEn  (selWrEn),
    .selWrData(selWrData),
    .trigWr   (trigWr),
    .trigBusy (trigBusy),
    .clkEnOut (clkEnOut),
    .activeSel(activeSel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Drive one cycle of staging writes, optionally with a trigger.
  task automatic stage(input int field, input int sel, input bit trig);
    divWrData = 12'(field);
    selWrData = 3'(sel);
    divWrEn   = 1'b1;
    selWrEn   = 1'b1;
    trigWr    = trig;
    step();
    divWrEn   = 1'b0;
    selWrEn   = 1'b0;
    trigWr    = 1'b0;
  endtask

  task automatic awaitCommit(output int w);
    w = 0;
    while (trigBusy && w < 400) begin
      step();
      w++;
    end
  endtask

  task automatic countPulses(input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (clkEnOut) cnt++;
    end
  endtask

  task automatic commitNew(input int field, input int sel);
    int w;
    int bound;
    stage(field, sel, 1'b1);
    check(trigBusy == 1'b1, "R4 busy after trigger", int'(trigBusy), 1);
    awaitCommit(w);
    bound = (curScaled + 15) / 16;
    check(!trigBusy && w >= 1 && w <= bound, "R4 commit latency", w, bound);
    check(int'(activeSel) == sel, "R4 select applied", int'(activeSel), sel);
    curScaled = field + 16;
  endtask

  task automatic rateCheck(input int field, input string req);
    int cnt;
    int expCnt;
    expCnt = (16 * NPULSE) / (field + 16);
    countPulses(NPULSE, cnt);
    check(cnt == expCnt, req, cnt, expCnt);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    int w;
    int field;
    bit busyHeld;
    bit quiet;

    repeat (3) step();
    rstN = 1'b1;
    gateEn = 1'b1;
    // R1: reset state
    check(trigBusy == 1'b0, "R1 busy", int'(trigBusy), 0);
    check(activeSel == 3'd7, "R1 select", int'(activeSel), 7);
    check(clkEnOut == 1'b0, "R1 enable", int'(clkEnOut), 0);

    // R7: reset select is undefined, so no pulses at all
    countPulses(30, cnt);
    check(cnt == 0, "R7 reset select quiet", cnt, 0);

    // R3: divisor 1.0 gives an enable on every cycle
    commitNew(0, 2);
    countPulses(64, cnt);
    check(cnt == 64, "R3 divide by one", cnt, 64);

    // R2: sweep of divisor fields, including both ends
    commitNew(4095, 1);
    rateCheck(4095, "R2 rate field 4095");
    for (int i = 0; i < 20; i++) begin
      field = (i * i * 37 + i * 113 + 5) % 4096;
      commitNew(field, i % 5);
      rateCheck(field, "R2 rate sweep");
    end

    // R5: staging without a trigger has no effect
    commitNew(40, 1);
    stage(3000, 3, 1'b0);
    countPulses(NPULSE, cnt);
    check(cnt == (16 * NPULSE) / 56, "R5 rate unchanged", cnt, (16 * NPULSE) / 56);
    check(activeSel == 3'd1, "R5 select unchanged", int'(activeSel), 1);

    // R8: writes during busy are ignored
    commitNew(4095, 0);
    stage(24, 2, 1'b1);
    check(trigBusy == 1'b1, "R8 busy before late write", int'(trigBusy), 1);
    stage(100, 4, 1'b1);
    check(trigBusy == 1'b1, "R8 still busy", int'(trigBusy), 1);
    awaitCommit(w);
    check(!trigBusy && w <= 257, "R8 commit seen", w, 257);
    check(activeSel == 3'd2, "R8 staged select kept", int'(activeSel), 2);
    curScaled = 40;
    rateCheck(24, "R8 staged divisor kept");

    // R6: gate closed holds the update and suppresses pulses
    gateEn = 1'b0;
    stage(8, 3, 1'b1);
    busyHeld = 1'b1;
    quiet = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (!trigBusy) busyHeld = 1'b0;
      if (clkEnOut) quiet = 1'b0;
      step();
    end
    check(busyHeld, "R6 busy held while gated", int'(busyHeld), 1);
    check(quiet, "R6 no pulse while gated", int'(quiet), 1);
    check(activeSel == 3'd2, "R6 select held while gated", int'(activeSel), 2);
    gateEn = 1'b1;
    awaitCommit(w);
    check(!trigBusy && w >= 1 && w <= 3, "R6 commit after gate opens", w, 3);
    check(activeSel == 3'd3, "R6 select applied", int'(activeSel), 3);
    curScaled = 24;
    rateCheck(8, "R6 rate after gate opens");

    // R7: undefined select forces the output low, still reported
    commitNew(0, 6);
    countPulses(50, cnt);
    check(cnt == 0, "R7 undefined select quiet", cnt, 0);
    check(activeSel == 3'd6, "R7 select reported", int'(activeSel), 6);
    commitNew(0, 4);
    countPulses(50, cnt);
    check(cnt == 50, "R3 divide by one on select 4", cnt, 50);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule